// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block sits beside a small 8-bit processor core and decides when the core must stop and run an interrupt handler. Five request sources feed it: two external inputs, two timer overflows and one serial channel. Each source gives a one-clock pulse, and that pulse sets a sticky request flag. The controller copies the flags into a sample register once per machine cycle. It then gates the sample with a byte-wide enable register and a per-source priority register. When a source wins, the controller tells the core to make a forced long call to that source's vector address.

The controller tracks which priority levels are in service. A running handler can be interrupted only by a request of strictly higher priority. When the core signals a return from interrupt, the most recently entered level is closed, and requests that were held back are considered again. The core, the timers and the serial peripheral are outside the block; they appear only as pulses and strobes. A small register port holds the enable byte, the priority byte and a flag register whose bits can be read and cleared by writing 1.

The call sequencer is a three-state machine:
- `SEQ_IDLE` moves to `SEQ_DETECT` on a machine-cycle tick when the arbiter finds an allowed winner in the sample.
- `SEQ_DETECT` moves to `SEQ_CALL` on the next tick. On that move it pulses the acknowledge, marks the winner's level in service and auto-clears the winner's flag.
- `SEQ_CALL` counts six ticks. It returns to `SEQ_IDLE` on the sixth tick and pulses the call-done output there.

Top module: `irq_nest_ctrl`

## Requirements
- R1: A source pulse sets its request flag whatever the enable and global bits hold. Flags read back at address 0x88, bits 4..0, with source index 0 external 0, 1 timer 0, 2 external 1, 3 timer 1 and 4 serial 0.
- R2: The enable register at address 0xA8 resets to 0x00.
  - Bit 7 is the global enable; when it is 0, no interrupt is taken.
  - Bits 4..0 enable sources 4..0.
  - Bit 6 is stored and read back but has no effect on gating.
  - Bit 5 always reads 0.
- R3: Flags are copied into the sample only on a machine-cycle tick, and detection uses the sample from an earlier tick. With a tick on every clock, `irq_ack` is high in the third clock after the edge that captures a request pulse, when the block is idle and no other source is pending.
- R4: `irq_ack` is a one-clock pulse issued one machine cycle after detection. While it is high, `irq_vec` equals 0x0003 + 8 × source index.
- R5: `call_done` pulses exactly six machine cycles after `irq_ack`, so the response is seven machine cycles from detection.
- R6: The priority register at address 0xB8 (bits 4..0, 1 = high level) resets to 0. Any eligible high-level source beats any low-level one. Within a level, the lowest source index wins.
- R7: A new request is taken only when its level is strictly above every level in service. Requests of equal or lower level stay pending, and they are taken once the level that blocked them is closed.
- R8: `svc_active[1]` marks the high level in service and `svc_active[0]` the low level. A return pulse clears the high bit if it is set, and otherwise the low bit.
- R9: On acknowledge, the winner's flag is cleared if it is source 0..3. The serial flag stays set until a write of 1 to bit 4 at address 0x88 clears it. A source pulse in the same clock as any clear leaves the flag set.
- R10: No new acknowledge is issued while a detection or call sequence is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mc_tick | input | 1 | One-clock strobe marking each machine cycle |
| src_evt | input | 5 | Request pulses, bit = source index |
| reti | input | 1 | Return-from-interrupt pulse from the core |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| irq_ack | output | 1 | Acknowledge pulse; core starts the forced long call |
| irq_vec | output | 16 | Vector address, valid with `irq_ack` |
| call_done | output | 1 | Pulse when the six-cycle call sequence ends |
| svc_active | output | 2 | In-service levels: bit 1 high, bit 0 low |

## Verification
The hardest state to reach is both levels in service at once, with a low request held back behind them. Reaching it needs a low-level handler already entered and not returned, then a high-level source fired. A second low source is then raised while both levels are busy. The bench builds this by firing external 0 and leaving it unreturned, then firing a high-priority timer 1, then raising external 1. It then sends two return pulses. The first must clear only the high bit, and the held-back source must still wait. The second must release it. A flag write and a source pulse landing in the same clock are also placed on purpose, with the serial enable off so that the result shows only in the flag register.

// File: rtl/irq_pkg.sv
package irq_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_DETECT = 2'd1,
        SEQ_CALL   = 2'd2
    } seq_state_t;

    localparam int LVL_LOW  = 0;
    localparam int LVL_HIGH = 1;

endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int N_SRC = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mc_tick,
    input  logic [N_SRC-1:0] src_evt,
    input  logic [N_SRC-1:0] ack_clr,
    input  logic [N_SRC-1:0] sw_clr,
    output logic [N_SRC-1:0] flags,
    output logic [N_SRC-1:0] sample
);

    // One sticky flag and one sampled copy per source.
    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flags[g] <= 1'b0;
            end else if (src_evt[g]) begin
                flags[g] <= 1'b1;           // a new pulse beats any clear
            end else if (ack_clr[g] || sw_clr[g]) begin
                flags[g] <= 1'b0;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sample[g] <= 1'b0;
            end else if (mc_tick) begin
                sample[g] <= flags[g];
            end
        end
    end

endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
    parameter int              N_SRC     = 5,
    parameter int              AW        = 8,
    parameter int              DW        = 8,
    parameter logic [AW-1:0]   EN_ADDR   = 8'hA8,
    parameter logic [AW-1:0]   PRIO_ADDR = 8'hB8,
    parameter logic [AW-1:0]   FLAG_ADDR = 8'h88,
    parameter int              GLB_BIT   = 7,
    parameter int              AUX_BIT   = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [AW-1:0]    reg_addr,
    input  logic [DW-1:0]    reg_wdata,
    input  logic [N_SRC-1:0] flags,
    output logic [DW-1:0]    reg_rdata,
    output logic [N_SRC-1:0] src_en,
    output logic             glb_en,
    output logic [N_SRC-1:0] prio_hi,
    output logic [N_SRC-1:0] sw_clr
);

    logic en_hit, pr_hit, fl_hit;
    logic aux_bit;

    assign en_hit = reg_we && (reg_addr == EN_ADDR);
    assign pr_hit = reg_we && (reg_addr == PRIO_ADDR);
    assign fl_hit = reg_we && (reg_addr == FLAG_ADDR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_en  <= '0;
            glb_en  <= 1'b0;
            aux_bit <= 1'b0;
        end else if (en_hit) begin
            src_en  <= reg_wdata[N_SRC-1:0];
            glb_en  <= reg_wdata[GLB_BIT];
            aux_bit <= reg_wdata[AUX_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prio_hi <= '0;
        end else if (pr_hit) begin
            prio_hi <= reg_wdata[N_SRC-1:0];
        end
    end

    // Write one to clear
    assign sw_clr = fl_hit ? reg_wdata[N_SRC-1:0] : '0;

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == EN_ADDR) begin
            reg_rdata[N_SRC-1:0] = src_en;
            reg_rdata[GLB_BIT]   = glb_en;
            reg_rdata[AUX_BIT]   = aux_bit;
        end else if (reg_addr == PRIO_ADDR) begin
            reg_rdata[N_SRC-1:0] = prio_hi;
        end else if (reg_addr == FLAG_ADDR) begin
            reg_rdata[N_SRC-1:0] = flags;
        end
    end

    logic unused_wdata;
    assign unused_wdata = ^reg_wdata;

endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
    parameter int N_SRC = 5,
    localparam int IDX_W = $clog2(N_SRC)
) (
    input  logic [N_SRC-1:0] sample,
    input  logic [N_SRC-1:0] src_en,
    input  logic             glb_en,
    input  logic [N_SRC-1:0] prio_hi,
    input  logic [1:0]       svc,
    output logic             take,
    output logic [IDX_W-1:0] win_idx,
    output logic             win_hi
);

    logic [N_SRC-1:0] elig, hi_set, lo_set;

    function automatic logic [IDX_W-1:0] first_set(input logic [N_SRC-1:0] v);
        logic [IDX_W-1:0] r;
        r = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (v[i]) r = IDX_W'(i);
        end
        return r;
    endfunction

    assign elig   = sample & src_en & {N_SRC{glb_en}};
    assign hi_set = elig & prio_hi;
    assign lo_set = elig & ~prio_hi;

    always_comb begin
        take    = 1'b0;
        win_idx = '0;
        win_hi  = 1'b0;
        if (!svc[irq_pkg::LVL_HIGH] && (|hi_set)) begin
            take    = 1'b1;
            win_hi  = 1'b1;
            win_idx = first_set(hi_set);
        end else if ((svc == 2'b00) && (|lo_set)) begin
            take    = 1'b1;
            win_idx = first_set(lo_set);
        end
    end

endmodule

// File: rtl/irq_sequencer.sv
module irq_sequencer
    import irq_pkg::*;
#(
    parameter int               N_SRC    = 5,
    parameter int               CALL_CYC = 6,
    parameter int               VEC_W    = 16,
    parameter int               VEC_BASE = 3,
    parameter int               VEC_STEP = 8,
    parameter logic [N_SRC-1:0] AUTO_CLR = 5'b01111,
    localparam int IDX_W = $clog2(N_SRC),
    localparam int CNT_W = $clog2(CALL_CYC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mc_tick,
    input  logic             reti,
    input  logic             take,
    input  logic [IDX_W-1:0] win_idx,
    input  logic             win_hi,
    output logic             irq_ack,
    output logic [VEC_W-1:0] irq_vec,
    output logic             call_done,
    output logic [1:0]       svc,
    output logic [N_SRC-1:0] ack_clr
);

    seq_state_t        state, state_nx;
    logic [IDX_W-1:0]  cur_idx;
    logic              cur_hi;
    logic [CNT_W-1:0]  cnt;
    logic              enter_call, last_call;
    logic [1:0]        svc_pop;

    assign enter_call = (state == SEQ_DETECT) && mc_tick;
    assign last_call  = (state == SEQ_CALL) && mc_tick && (cnt == CNT_W'(CALL_CYC - 1));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SEQ_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            SEQ_IDLE:   if (mc_tick && take) state_nx = SEQ_DETECT;
            SEQ_DETECT: if (mc_tick)         state_nx = SEQ_CALL;
            SEQ_CALL:   if (last_call)       state_nx = SEQ_IDLE;
            default:                         state_nx = SEQ_IDLE;
        endcase
    end

    // Outputs and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_ack   <= 1'b0;
            call_done <= 1'b0;
            cur_idx   <= '0;
            cur_hi    <= 1'b0;
            cnt       <= '0;
        end else begin
            irq_ack   <= enter_call;
            call_done <= last_call;
            if ((state == SEQ_IDLE) && mc_tick && take) begin
                cur_idx <= win_idx;
                cur_hi  <= win_hi;
            end
            if (enter_call)                          cnt <= '0;
            else if ((state == SEQ_CALL) && mc_tick) cnt <= cnt + 1'b1;
        end
    end

    // In-service levels: close the newest level first, then mark the entered one
    always_comb begin
        svc_pop = svc;
        if (reti) begin
            if (svc[LVL_HIGH]) svc_pop[LVL_HIGH] = 1'b0;
            else               svc_pop[LVL_LOW]  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            svc <= 2'b00;
        end else begin
            svc <= svc_pop;
            if (enter_call) svc[cur_hi] <= 1'b1;
        end
    end

    for (genvar g = 0; g < N_SRC; g++) begin : g_clr
        assign ack_clr[g] = enter_call && (cur_idx == IDX_W'(g)) && AUTO_CLR[g];
    end

    assign irq_vec = VEC_W'(VEC_BASE) + VEC_W'(cur_idx) * VEC_W'(VEC_STEP);

endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl #(
    parameter int          N_SRC     = 5,
    parameter int          AW        = 8,
    parameter int          DW        = 8,
    parameter int          VEC_W     = 16,
    parameter int          CALL_CYC  = 6,
    parameter int          VEC_BASE  = 3,
    parameter int          VEC_STEP  = 8,
    parameter logic [7:0]  EN_ADDR   = 8'hA8,
    parameter logic [7:0]  PRIO_ADDR = 8'hB8,
    parameter logic [7:0]  FLAG_ADDR = 8'h88
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mc_tick,
    input  logic [N_SRC-1:0] src_evt,
    input  logic             reti,
    input  logic             reg_we,
    input  logic [AW-1:0]    reg_addr,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    reg_rdata,
    output logic             irq_ack,
    output logic [VEC_W-1:0] irq_vec,
    output logic             call_done,
    output logic [1:0]       svc_active
);

    localparam int IDX_W = $clog2(N_SRC);
    localparam logic [N_SRC-1:0] AUTO_CLR = {1'b0, {(N_SRC-1){1'b1}}};

    logic [N_SRC-1:0] flags, sample, src_en, prio_hi, sw_clr, ack_clr;
    logic             glb_en, take, win_hi;
    logic [IDX_W-1:0] win_idx;

    irq_flag_bank #(.N_SRC(N_SRC)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .mc_tick (mc_tick),
        .src_evt (src_evt),
        .ack_clr (ack_clr),
        .sw_clr  (sw_clr),
        .flags   (flags),
        .sample  (sample)
    );

    irq_cfg_regs #(
        .N_SRC     (N_SRC),
        .AW        (AW),
        .DW        (DW),
        .EN_ADDR   (AW'(EN_ADDR)),
        .PRIO_ADDR (AW'(PRIO_ADDR)),
        .FLAG_ADDR (AW'(FLAG_ADDR))
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .flags     (flags),
        .reg_rdata (reg_rdata),
        .src_en    (src_en),
        .glb_en    (glb_en),
        .prio_hi   (prio_hi),
        .sw_clr    (sw_clr)
    );

    irq_pick #(.N_SRC(N_SRC)) u_pick (
        .sample  (sample),
        .src_en  (src_en),
        .glb_en  (glb_en),
        .prio_hi (prio_hi),
        .svc     (svc_active),
        .take    (take),
        .win_idx (win_idx),
        .win_hi  (win_hi)
    );

    irq_sequencer #(
        .N_SRC    (N_SRC),
        .CALL_CYC (CALL_CYC),
        .VEC_W    (VEC_W),
        .VEC_BASE (VEC_BASE),
        .VEC_STEP (VEC_STEP),
        .AUTO_CLR (AUTO_CLR)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .mc_tick   (mc_tick),
        .reti      (reti),
        .take      (take),
        .win_idx   (win_idx),
        .win_hi    (win_hi),
        .irq_ack   (irq_ack),
        .irq_vec   (irq_vec),
        .call_done (call_done),
        .svc       (svc_active),
        .ack_clr   (ack_clr)
    );

endmodule

// File: rtl/irq_nest_ctrl_chk.sv
module irq_nest_ctrl_chk #(
    parameter int N_SRC    = 5,
    parameter int VEC_W    = 16,
    parameter int CALL_CYC = 6,
    parameter int VEC_BASE = 3,
    parameter int VEC_STEP = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mc_tick,
    input logic             reti,
    input logic             irq_ack,
    input logic [VEC_W-1:0] irq_vec,
    input logic             call_done,
    input logic [1:0]       svc_active
);

    logic          wait_on;
    logic [15:0]   tk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wait_on <= 1'b0;
            tk      <= '0;
        end else begin
            if (irq_ack) begin
                wait_on <= 1'b1;
                tk      <= mc_tick ? 16'd1 : 16'd0;
            end else if (call_done) begin
                wait_on <= 1'b0;
            end else if (wait_on && mc_tick) begin
                tk <= tk + 16'd1;
            end
        end
    end

    // R4: vector lies on the source grid
    a_r4_vec_on_grid: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> ((int'(irq_vec) >= VEC_BASE) &&
                     ((int'(irq_vec) - VEC_BASE) % VEC_STEP == 0) &&
                     (int'(irq_vec) < VEC_BASE + N_SRC * VEC_STEP)));

    // R5: call ends after the exact number of machine cycles
    a_r5_call_length: assert property (@(posedge clk) disable iff (!rst_n)
        call_done |-> (wait_on && tk == 16'(CALL_CYC)));

    // R10: no acknowledge inside a running call
    a_r10_no_ack_in_call: assert property (@(posedge clk) disable iff (!rst_n)
        wait_on |-> !irq_ack);

    // R7: acknowledge always opens a service level
    a_r7_ack_marks_service: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> (svc_active != 2'b00));

    // R8: return with both levels open closes the high one only
    a_r8_reti_high_first: assert property (@(posedge clk) disable iff (!rst_n)
        (reti && svc_active == 2'b11) |=> (svc_active[0] && (!svc_active[1] || irq_ack)));

endmodule

bind irq_nest_ctrl irq_nest_ctrl_chk #(
    .N_SRC    (N_SRC),
    .VEC_W    (VEC_W),
    .CALL_CYC (CALL_CYC),
    .VEC_BASE (VEC_BASE),
    .VEC_STEP (VEC_STEP)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mc_tick    (mc_tick),
    .reti       (reti),
    .irq_ack    (irq_ack),
    .irq_vec    (irq_vec),
    .call_done  (call_done),
    .svc_active (svc_active)
);

// File: tb/sim_irq_nest_ctrl.sv
module sim_irq_nest_ctrl;

    localparam int CLK_PER = 10;
    localparam logic [7:0] A_EN = 8'hA8, A_PR = 8'hB8, A_FL = 8'h88;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mc_tick = 1'b1;
    logic [4:0] src_evt = '0;
    logic       reti = 1'b0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq_ack;
    logic [15:0] irq_vec;
    logic       call_done;
    logic [1:0] svc_active;

    int checks = 0;
    int errors = 0;
    int tick_div = 1;
    int tcnt = 0;
    bit done_flag = 0;

    always #(CLK_PER/2) clk = ~clk;

    irq_nest_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .src_evt(src_evt), .reti(reti),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_ack(irq_ack), .irq_vec(irq_vec), .call_done(call_done), .svc_active(svc_active)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Machine-cycle strobe
    always @(negedge clk) begin
        tcnt++;
        mc_tick <= ((tcnt % tick_div) == 0);
    end

    // ---------------- behavioural reference model ----------------
    logic [4:0] m_flag, m_samp, m_en, m_pr, m_clr, m_sw;
    logic       m_glb, m_aux, m_ack, m_done;
    logic [1:0] m_svc;
    int         m_st, m_cnt, m_win, m_whi, m_lvl, m_found;

    function automatic logic [7:0] m_read(input logic [7:0] a);
        if (a == A_EN) return {m_glb, m_aux, 1'b0, m_en};
        if (a == A_PR) return {3'b000, m_pr};
        if (a == A_FL) return {3'b000, m_flag};
        return 8'h00;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_flag = '0; m_samp = '0; m_en = '0; m_pr = '0; m_glb = 0; m_aux = 0;
            m_ack = 0; m_done = 0; m_svc = 2'b00; m_st = 0; m_cnt = 0; m_win = 0; m_whi = 0;
        end else begin
            m_clr = '0;
            m_lvl = m_svc[1] ? 2 : (m_svc[0] ? 1 : 0);
            m_ack = 0; m_done = 0;
            if (reti) begin
                if (m_svc[1]) m_svc[1] = 1'b0; else m_svc[0] = 1'b0;
            end
            if (m_st == 0) begin
                if (mc_tick) begin
                    m_found = 0;
                    for (int p = 1; p >= 0; p--)
                        for (int i = 0; i < 5; i++)
                            if (!m_found && m_lvl <= p && m_samp[i] && m_en[i] && m_glb && (m_pr[i] == p[0])) begin
                                m_found = 1; m_win = i; m_whi = p;
                            end
                    if (m_found) m_st = 1;
                end
            end else if (m_st == 1) begin
                if (mc_tick) begin
                    m_ack = 1; m_svc[m_whi] = 1'b1;
                    if (m_win != 4) m_clr[m_win] = 1'b1;
                    m_st = 2; m_cnt = 0;
                end
            end else begin
                if (mc_tick) begin
                    if (m_cnt == 5) begin m_done = 1; m_st = 0; end
                    else m_cnt++;
                end
            end
            m_sw = (reg_we && reg_addr == A_FL) ? reg_wdata[4:0] : 5'b0;
            if (mc_tick) m_samp = m_flag;
            m_flag = (m_flag & ~(m_clr | m_sw)) | src_evt;
            if (reg_we && reg_addr == A_EN) begin m_en = reg_wdata[4:0]; m_glb = reg_wdata[7]; m_aux = reg_wdata[6]; end
            if (reg_we && reg_addr == A_PR) m_pr = reg_wdata[4:0];
        end
        #2;
        check(irq_ack === m_ack, "R4 ack vs model", int'(irq_ack), int'(m_ack));
        check(call_done === m_done, "R5 call_done vs model", int'(call_done), int'(m_done));
        check(svc_active === m_svc, "R8 svc vs model", int'(svc_active), int'(m_svc));
        check(reg_rdata === m_read(reg_addr), "R2 rdata vs model", int'(reg_rdata), int'(m_read(reg_addr)));
        if (m_ack) check(irq_vec === 16'(3 + 8 * m_win), "R4 vec vs model", int'(irq_vec), 3 + 8 * m_win);
    end

    // ---------------- stimulus helpers ----------------
    task automatic fire(input logic [4:0] m);
        @(negedge clk); src_evt = m;
        @(negedge clk); src_evt = '0;
    endtask

    task automatic wreg(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 0;
    endtask

    task automatic rchk(input logic [7:0] a, input logic [7:0] e, input string tag);
        @(negedge clk); reg_addr = a; #1;
        check(reg_rdata === e, tag, int'(reg_rdata), int'(e));
    endtask

    task automatic pulse_reti();
        @(negedge clk); reti = 1;
        @(negedge clk); reti = 0;
    endtask

    task automatic no_ack(input int n, input string tag);
        for (int k = 0; k < n; k++) begin
            @(posedge clk); #3;
            check(irq_ack === 1'b0, tag, int'(irq_ack), 0);
        end
    endtask

    task automatic wait_ack(input logic [15:0] ev, input string tag);
        bit got = 0;
        for (int k = 0; k < 400; k++) begin
            @(posedge clk); #3;
            if (irq_ack) begin got = 1; break; end
        end
        check(got, {tag, " ack seen"}, int'(got), 1);
        check(irq_vec === ev, {tag, " vector"}, int'(irq_vec), int'(ev));
    endtask

    task automatic chk_done(input int clocks);
        for (int k = 1; k < clocks; k++) begin
            @(posedge clk); #3;
            check(call_done === 1'b0, "R5 done early", int'(call_done), 0);
        end
        @(posedge clk); #3;
        check(call_done === 1'b1, "R5 done on sixth cycle", int'(call_done), 1);
    endtask

    task automatic chk_svc(input logic [1:0] e, input string tag);
        @(negedge clk);
        check(svc_active === e, tag, int'(svc_active), int'(e));
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (50000) @(posedge clk);
        if (!done_flag) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // ---------------- directed sequence ----------------
    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;

        // reset state (R2, R6, R1)
        rchk(A_EN, 8'h00, "R2 enable reset");
        rchk(A_PR, 8'h00, "R6 priority reset");
        rchk(A_FL, 8'h00, "R1 flags reset");
        check(irq_ack === 0 && svc_active === 0, "R8 idle after reset", int'(svc_active), 0);

        // R1: flag set with everything disabled, no acknowledge
        fire(5'b00001);
        no_ack(10, "R1 disabled source must not ack");
        rchk(A_FL, 8'h01, "R1 flag set while disabled");
        wreg(A_FL, 8'h01);
        rchk(A_FL, 8'h00, "R9 software clear");

        // R2: bit 5 reads zero, bit 6 has no gating effect
        wreg(A_EN, 8'hFF);
        rchk(A_EN, 8'hDF, "R2 bit5 reads zero");
        wreg(A_EN, 8'h5F);
        fire(5'b00001);
        no_ack(10, "R2 global off with bit6 set");
        rchk(A_EN, 8'h5F, "R2 bit6 stored");
        wreg(A_EN, 8'h81);
        wait_ack(16'h0003, "R4 ext0");
        chk_done(6);
        chk_svc(2'b01, "R8 low level open");
        rchk(A_FL, 8'h00, "R9 ext0 auto clear");
        pulse_reti();
        chk_svc(2'b00, "R8 reti closes low");

        // R3: exact detection latency
        wreg(A_EN, 8'h9F);
        fire(5'b00010);
        @(posedge clk); #3; check(irq_ack === 0, "R3 ack not yet (1)", int'(irq_ack), 0);
        @(posedge clk); #3; check(irq_ack === 0, "R3 ack not yet (2)", int'(irq_ack), 0);
        @(posedge clk); #3; check(irq_ack === 1, "R3 ack third clock", int'(irq_ack), 1);
        check(irq_vec === 16'h000B, "R4 tmr0 vector", int'(irq_vec), 16'h000B);
        chk_done(6);
        pulse_reti();

        // R6 order within a level, R7 equal level waits
        fire(5'b00110);
        wait_ack(16'h000B, "R6 tmr0 before ext1");
        chk_done(6);
        no_ack(12, "R7 equal level stays pending");
        pulse_reti();
        wait_ack(16'h0013, "R7 ext1 after return");
        chk_done(6);
        pulse_reti();

        // R6 high level beats lower index
        wreg(A_PR, 8'h08);
        rchk(A_PR, 8'h08, "R6 priority write");
        fire(5'b01001);
        wait_ack(16'h001B, "R6 high tmr1 wins");
        chk_done(6);
        chk_svc(2'b10, "R8 high level open");
        no_ack(10, "R7 low blocked by high");
        pulse_reti();
        wait_ack(16'h0003, "R7 ext0 after high return");
        chk_done(6);
        pulse_reti();

        // Nesting: low, then high preempts, low waits behind both
        fire(5'b00001);
        wait_ack(16'h0003, "R7 low entered");
        chk_done(6);
        fire(5'b01000);
        wait_ack(16'h001B, "R7 high preempts low");
        chk_done(6);
        chk_svc(2'b11, "R8 both levels open");
        fire(5'b00100);
        no_ack(10, "R7 low blocked when both open");
        pulse_reti();
        chk_svc(2'b01, "R8 high closed first");
        no_ack(10, "R7 low still blocked by low");
        pulse_reti();
        wait_ack(16'h0013, "R7 ext1 released");
        chk_done(6);
        pulse_reti();

        // R9 serial flag stays set after ack
        wreg(A_PR, 8'h00);
        fire(5'b10000);
        wait_ack(16'h0023, "R4 serial");
        chk_done(6);
        rchk(A_FL, 8'h10, "R9 serial flag kept");
        wreg(A_FL, 8'h10);
        rchk(A_FL, 8'h00, "R9 serial cleared by write");
        pulse_reti();
        no_ack(10, "R9 no retrigger after clear");

        // R9 pulse and clear in the same clock: pulse wins
        wreg(A_EN, 8'h8F);
        @(negedge clk); src_evt = 5'b10000; reg_we = 1; reg_addr = A_FL; reg_wdata = 8'h10;
        @(negedge clk); src_evt = '0; reg_we = 0;
        rchk(A_FL, 8'h10, "R9 pulse beats clear");
        wreg(A_FL, 8'h10);

        // R3/R5 with sparse machine cycles
        wreg(A_EN, 8'h9F);
        tick_div = 3;
        repeat (6) @(negedge clk);
        fire(5'b00100);
        wait_ack(16'h0013, "R3 sparse tick ack");
        chk_done(18);
        pulse_reti();
        repeat (6) @(negedge clk);
        chk_svc(2'b00, "R8 closed in sparse mode");

        // R10 covered by model compare each clock; final idle
        no_ack(6, "R10 idle at end");

        done_flag = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule